// File: doc/BRIEF.md
# Pipelined Single-Pass Switch Allocator

This block decides, every clock cycle, which waiting packets of an input-buffered router may cross the crossbar. It serves eight input ports and seven output ports. Each input port keeps a small queue of packet descriptors. A descriptor holds a destination output, a one-bit class, and a length in cycles. The class tells a packet already travelling through the network apart from one injected by a local source.

Allocation is one pass through a three-stage pipeline. In the first stage every input independently offers one packet. In the second stage every output independently picks one of the offers it received. Offers that are not picked are collisions. They get no grant and stay queued for a later try. The third stage issues the grants and marks each granted output busy for the length of its packet.

A new allocation round starts every cycle, so up to three rounds are in flight at once. Packet data movement, route computation and credit flow are handled elsewhere. The block only reports which input owns which output.

Top module: `xbar_alloc`

## Requirements
- R1: An enqueue on `enqValid[i]` stores the descriptor in the lowest empty slot of input i's four-slot queue. The enqueue is ignored when `queueFull[i]` is high, or when the destination code is 7 or more (outputs are numbered 0..6). `queueFull[i]` is high exactly while all four slots are occupied.
- R2: Timing of a grant on an idle output. A packet enqueued in cycle c is in the queue snapshot of cycle c+1. Its grant appears in cycle c+4 as `grantValid[o]` high with `grantInput[o*3 +: 3]` equal to the input number.
- R3: Each input offers its oldest queued packet that targets a free output and is not already in the pipeline. Age is time spent in the queue, not slot position.
- R4: Each output grants at most one offer per cycle, and no input is granted on two outputs in the same cycle. A losing packet stays queued with its age kept and is offered again later.
- R5: At one output, an offer of class network (`enqNet`=1) always beats an offer of class local (`enqNet`=0).
- R6: Within one class, each output chooses round-robin over the inputs. The search starts at its pointer, which is reset to 0 and moves to one past the winner only when a grant is issued.
- R7: A grant makes `outBusy[o]` high from the grant cycle for exactly the packet's length in cycles; a length of 0 counts as 1. `outBusy[o]` never rises without a grant.
- R8: A busy output receives no grant. Packets waiting for it are granted only after it becomes free.
- R9: A granted packet leaves its input queue at the grant, so its slot frees in the grant cycle.
- R10: Synchronous active-high `rst` empties all queues, clears busy state, returns the round-robin pointers to 0, and flushes the pipeline so that no grant follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enqValid | input | 8 | Per-input enqueue strobe |
| enqNet | input | 8 | Per-input class bit: 1 network, 0 local |
| enqDest | input | 24 | Per-input destination output, 3 bits each |
| enqLen | input | 32 | Per-input packet length in cycles, 4 bits each |
| queueFull | output | 8 | Per-input queue has no empty slot |
| grantValid | output | 7 | Per-output grant issued this cycle |
| grantInput | output | 21 | Per-output granted input number, 3 bits each |
| outBusy | output | 7 | Per-output transfer in progress |

## Verification
A lone packet on an idle output fixes the three-stage latency and the busy window. Two packets meeting at one output separate the class priority from the round-robin order. A pointer deliberately moved away from zero shows that the choice is not a fixed lowest-input preference. An input holding an older, shorter packet in a higher slot and a younger, longer one in a lower slot shows age order against slot order, through the length of the busy window that follows. A queue filled behind a long transfer covers full-queue rejection, waiting on a busy output, retirement at the grant, and the retry rhythm of collided packets. A reset in the middle of a round shows the flush and the cleared pointers.

// File: rtl/xbar_alloc_pkg.sv
package xbar_alloc_pkg;

  localparam int NUM_IN  = 8;
  localparam int NUM_OUT = 7;
  localparam int QDEPTH  = 4;
  localparam int LEN_W   = 4;
  localparam int AGE_W   = 6;

  localparam int IN_W   = $clog2(NUM_IN);
  localparam int OUT_W  = $clog2(NUM_OUT);
  localparam int SLOT_W = $clog2(QDEPTH);

  // One offer from an input arbiter, registered at the end of stage one.
  typedef struct packed {
    logic              valid;
    logic              net;
    logic [OUT_W-1:0]  dest;
    logic [SLOT_W-1:0] slot;
    logic [LEN_W-1:0]  len;
  } nom_t;

  // Strobes from the output side back to the queues.
  typedef struct packed {
    logic [NUM_IN-1:0]             drop;
    logic [NUM_IN-1:0]             retire;
    logic [NUM_IN-1:0][SLOT_W-1:0] dropSlot;
    logic [NUM_IN-1:0][SLOT_W-1:0] retireSlot;
  } strobe_t;

endpackage

// File: rtl/xbar_alloc_rr.sv
module xbar_alloc_rr #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         any,
  output logic [W-1:0] idx
);

  // Search starts at ptr and wraps around; the first requester wins.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      int p;
      p = int'(ptr) + k;
      if (p >= N) p = p - N;
      if (req[p] && !any) begin
        any = 1'b1;
        idx = W'(p);
      end
    end
  end

endmodule

// File: rtl/xbar_alloc_queue.sv
module xbar_alloc_queue
  import xbar_alloc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_IN-1:0]             enqValid,
  input  logic [NUM_IN-1:0]             enqNet,
  input  logic [NUM_IN-1:0][OUT_W-1:0]  enqDest,
  input  logic [NUM_IN-1:0][LEN_W-1:0]  enqLen,
  input  logic [NUM_OUT-1:0]            outFree,
  input  strobe_t                       strb,
  output nom_t [NUM_IN-1:0]             nomQ,
  output logic [NUM_IN-1:0]             queueFull
);

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : gIn
    logic [QDEPTH-1:0]             slotValid;
    logic [QDEPTH-1:0]             slotInFlight;
    logic [QDEPTH-1:0][AGE_W-1:0]  slotAge;
    logic [QDEPTH-1:0]             slotNet;
    logic [QDEPTH-1:0][OUT_W-1:0]  slotDest;
    logic [QDEPTH-1:0][LEN_W-1:0]  slotLen;

    logic              freeFound;
    logic [SLOT_W-1:0] freeIdx;
    logic              pickFound;
    logic [SLOT_W-1:0] pickIdx;
    logic [AGE_W-1:0]  bestAge;
    logic              accept;
    nom_t              nomReg;

    // Stage one: pick the oldest eligible packet; the strict compare keeps
    // the lower slot on equal ages.
    always_comb begin
      freeFound = 1'b0;
      freeIdx   = '0;
      pickFound = 1'b0;
      pickIdx   = '0;
      bestAge   = '0;
      for (int s = 0; s < QDEPTH; s++) begin
        if (!slotValid[s] && !freeFound) begin
          freeFound = 1'b1;
          freeIdx   = SLOT_W'(s);
        end
        if (slotValid[s] && !slotInFlight[s] && outFree[slotDest[s]]) begin
          if (!pickFound || slotAge[s] > bestAge) begin
            pickFound = 1'b1;
            pickIdx   = SLOT_W'(s);
            bestAge   = slotAge[s];
          end
        end
      end
      accept = enqValid[gi] && freeFound && (enqDest[gi] < OUT_W'(NUM_OUT));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        slotValid    <= '0;
        slotInFlight <= '0;
        slotAge      <= '0;
        slotNet      <= '0;
        slotDest     <= '0;
        slotLen      <= '0;
        nomReg       <= '0;
      end else begin
        for (int s = 0; s < QDEPTH; s++) begin
          if (slotValid[s] && slotAge[s] != '1) slotAge[s] <= slotAge[s] + 1'b1;
        end
        if (accept) begin
          slotValid[freeIdx]    <= 1'b1;
          slotInFlight[freeIdx] <= 1'b0;
          slotAge[freeIdx]      <= '0;
          slotNet[freeIdx]      <= enqNet[gi];
          slotDest[freeIdx]     <= enqDest[gi];
          slotLen[freeIdx]      <= enqLen[gi];
        end
        nomReg.valid <= pickFound;
        nomReg.net   <= slotNet[pickIdx];
        nomReg.dest  <= slotDest[pickIdx];
        nomReg.slot  <= pickIdx;
        nomReg.len   <= slotLen[pickIdx];
        if (pickFound) slotInFlight[pickIdx] <= 1'b1;
        if (strb.drop[gi]) slotInFlight[strb.dropSlot[gi]] <= 1'b0;
        if (strb.retire[gi]) begin
          slotValid[strb.retireSlot[gi]]    <= 1'b0;
          slotInFlight[strb.retireSlot[gi]] <= 1'b0;
        end
      end
    end

    assign nomQ[gi]      = nomReg;
    assign queueFull[gi] = &slotValid;
  end

endmodule

// File: rtl/xbar_alloc_ctrl.sv
module xbar_alloc_ctrl
  import xbar_alloc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  nom_t [NUM_IN-1:0]             nomQ,
  output strobe_t                       strb,
  output logic [NUM_OUT-1:0]            outFree,
  output logic [NUM_OUT-1:0]            grantValid,
  output logic [NUM_OUT-1:0][IN_W-1:0]  grantInput,
  output logic [NUM_OUT-1:0]            outBusy
);

  logic [NUM_OUT-1:0]             winAny;
  logic [NUM_OUT-1:0][IN_W-1:0]   winIdx;
  logic [NUM_OUT-1:0]             selValid;
  logic [NUM_OUT-1:0][IN_W-1:0]   selInp;
  logic [NUM_OUT-1:0][SLOT_W-1:0] selSlotV;

  for (genvar go = 0; go < NUM_OUT; go++) begin : gOut
    logic [NUM_IN-1:0] req;
    logic [NUM_IN-1:0] netReq;
    logic [NUM_IN-1:0] cand;
    logic              avail;
    logic [IN_W-1:0]   ptr;
    logic              pickAny;
    logic [IN_W-1:0]   pick;
    logic              selV;
    logic [IN_W-1:0]   selIn;
    logic [SLOT_W-1:0] selSlot;
    logic [LEN_W-1:0]  selLen;
    logic [LEN_W-1:0]  busyCnt;
    logic              gV;
    logic [IN_W-1:0]   gIn;

    // Stage two: network class first, round-robin inside the class.
    always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
        req[i]    = nomQ[i].valid && (nomQ[i].dest == OUT_W'(go));
        netReq[i] = req[i] && nomQ[i].net;
      end
      avail = (busyCnt == '0) && !selV;
      cand  = avail ? ((|netReq) ? netReq : req) : '0;
    end

    xbar_alloc_rr #(.N(NUM_IN), .W(IN_W)) uPick (
      .req (cand),
      .ptr (ptr),
      .any (pickAny),
      .idx (pick)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr     <= '0;
        selV    <= 1'b0;
        selIn   <= '0;
        selSlot <= '0;
        selLen  <= '0;
        busyCnt <= '0;
        gV      <= 1'b0;
        gIn     <= '0;
      end else begin
        selV    <= pickAny;
        selIn   <= pick;
        selSlot <= nomQ[pick].slot;
        selLen  <= nomQ[pick].len;
        if (pickAny) ptr <= (pick == IN_W'(NUM_IN - 1)) ? '0 : pick + 1'b1;
        // Stage three: deliver the grant and start the busy window.
        gV  <= selV;
        gIn <= selIn;
        if (selV) busyCnt <= (selLen == '0) ? LEN_W'(1) : selLen;
        else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
      end
    end

    assign winAny[go]     = pickAny;
    assign winIdx[go]     = pick;
    assign selValid[go]   = selV;
    assign selInp[go]     = selIn;
    assign selSlotV[go]   = selSlot;
    assign grantValid[go] = gV;
    assign grantInput[go] = gIn;
    assign outBusy[go]    = (busyCnt != '0);
    assign outFree[go]    = (busyCnt == '0);
  end

  // Losers of stage two are released; stage-three winners are retired.
  always_comb begin
    strb = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      strb.drop[i]     = nomQ[i].valid;
      strb.dropSlot[i] = nomQ[i].slot;
    end
    for (int o = 0; o < NUM_OUT; o++) begin
      if (winAny[o]) strb.drop[winIdx[o]] = 1'b0;
      if (selValid[o]) begin
        strb.retire[selInp[o]]     = 1'b1;
        strb.retireSlot[selInp[o]] = selSlotV[o];
      end
    end
  end

endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_alloc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IN-1:0]         enqValid,
  input  logic [NUM_IN-1:0]         enqNet,
  input  logic [NUM_IN*OUT_W-1:0]   enqDest,
  input  logic [NUM_IN*LEN_W-1:0]   enqLen,
  output logic [NUM_IN-1:0]         queueFull,
  output logic [NUM_OUT-1:0]        grantValid,
  output logic [NUM_OUT*IN_W-1:0]   grantInput,
  output logic [NUM_OUT-1:0]        outBusy
);

  logic [NUM_IN-1:0][OUT_W-1:0]  destArr;
  logic [NUM_IN-1:0][LEN_W-1:0]  lenArr;
  logic [NUM_OUT-1:0][IN_W-1:0]  grantArr;
  logic [NUM_OUT-1:0]            outFree;
  nom_t [NUM_IN-1:0]             nomQ;
  strobe_t                       strb;

  assign destArr    = enqDest;
  assign lenArr     = enqLen;
  assign grantInput = grantArr;

  xbar_alloc_queue uQueue (
    .clk       (clk),
    .rst       (rst),
    .enqValid  (enqValid),
    .enqNet    (enqNet),
    .enqDest   (destArr),
    .enqLen    (lenArr),
    .outFree   (outFree),
    .strb      (strb),
    .nomQ      (nomQ),
    .queueFull (queueFull)
  );

  xbar_alloc_ctrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .nomQ       (nomQ),
    .strb       (strb),
    .outFree    (outFree),
    .grantValid (grantValid),
    .grantInput (grantArr),
    .outBusy    (outBusy)
  );

endmodule

// File: rtl/xbar_alloc_chk.sv
module xbar_alloc_chk
  import xbar_alloc_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_OUT-1:0]      grantValid,
  input logic [NUM_OUT*IN_W-1:0] grantInput,
  input logic [NUM_OUT-1:0]      outBusy
);

  // R10: the cycle after a reset edge carries no grant.
  p_reset_flush_r10: assert property (@(posedge clk)
    rst |=> (grantValid == '0));

  for (genvar go = 0; go < NUM_OUT; go++) begin : gPer
    // R7: the grant cycle is inside the busy window.
    p_busy_at_grant_r7: assert property (@(posedge clk) disable iff (rst)
      grantValid[go] |-> outBusy[go]);
    // R7: busy never starts without a grant.
    p_busy_rises_on_grant_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(outBusy[go]) |-> grantValid[go]);
    // R8: a grant only lands on an output that was free the cycle before.
    p_grant_only_when_free_r8: assert property (@(posedge clk) disable iff (rst)
      grantValid[go] |-> !$past(outBusy[go]));
  end

  for (genvar ga = 0; ga < NUM_OUT; ga++) begin : gA
    for (genvar gb = ga + 1; gb < NUM_OUT; gb++) begin : gB
      // R4: one input never owns two outputs in the same cycle.
      p_distinct_inputs_r4: assert property (@(posedge clk) disable iff (rst)
        (grantValid[ga] && grantValid[gb]) |->
          (grantInput[ga*IN_W +: IN_W] != grantInput[gb*IN_W +: IN_W]));
    end
  end

endmodule

bind xbar_alloc xbar_alloc_chk uChk (
  .clk        (clk),
  .rst        (rst),
  .grantValid (grantValid),
  .grantInput (grantInput),
  .outBusy    (outBusy)
);

// File: tb/xbar_alloc_bench.sv
module xbar_alloc_bench;
  import xbar_alloc_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                    rst = 1'b1;
  logic [NUM_IN-1:0]       enqValid = '0;
  logic [NUM_IN-1:0]       enqNet = '0;
  logic [NUM_IN*OUT_W-1:0] enqDest = '0;
  logic [NUM_IN*LEN_W-1:0] enqLen = '0;
  logic [NUM_IN-1:0]       queueFull;
  logic [NUM_OUT-1:0]      grantValid;
  logic [NUM_OUT*IN_W-1:0] grantInput;
  logic [NUM_OUT-1:0]      outBusy;

  xbar_alloc u_xbar_alloc (
    .clk(clk), .rst(rst), .enqValid(enqValid), .enqNet(enqNet),
    .enqDest(enqDest), .enqLen(enqLen), .queueFull(queueFull),
    .grantValid(grantValid), .grantInput(grantInput), .outBusy(outBusy)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int c; int o; int i; string r; } exp_t;
  exp_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic put(int i, int d, bit n, int l);
    enqValid[i] = 1'b1;
    enqNet[i]   = n;
    enqDest[i*OUT_W +: OUT_W] = OUT_W'(d);
    enqLen[i*LEN_W +: LEN_W]  = LEN_W'(l);
  endtask

  task automatic tick();
    @(negedge clk);
    enqValid = '0;
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expectAt(int c, int o, int i, string r);
    exp_t e;
    e.c = c; e.o = o; e.i = i; e.r = r;
    expQ.push_back(e);
  endtask

  // Monitor: pops expected grants due this cycle, flags any extra grant.
  always @(negedge clk) begin : mon
    logic [NUM_OUT-1:0] seen;
    exp_t e;
    int act;
    seen = '0;
    if (!rst) begin
      while (expQ.size() > 0 && expQ[0].c <= cyc) begin
        e = expQ.pop_front();
        if (e.c < cyc) begin
          check(1'b0, e.r, $sformatf("grant overdue on output %0d", e.o), 0, 1);
        end else begin
          act = grantValid[e.o] ? int'(grantInput[e.o*IN_W +: IN_W]) : -1;
          check(act == e.i, e.r, $sformatf("grant on output %0d at cycle %0d", e.o, cyc), act, e.i);
          seen[e.o] = 1'b1;
        end
      end
      if ((grantValid & ~seen) != '0)
        check(1'b0, "R4", "unexpected grant mask", int'(grantValid), int'(seen));
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired (all requirements): actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : driver
    int c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: state right after reset
    check(grantValid == '0, "R10", "grantValid after reset", int'(grantValid), 0);
    check(outBusy == '0, "R10", "outBusy after reset", int'(outBusy), 0);
    check(queueFull == '0, "R10", "queueFull after reset", int'(queueFull), 0);

    // R2 / R7: single packet on idle output 2, length 3
    c = cyc;
    put(0, 2, 1'b1, 3); tick();
    expectAt(c + 4, 2, 0, "R2");
    waitUntil(c + 4);
    check(outBusy[2] == 1'b1, "R7", "busy in grant cycle", int'(outBusy[2]), 1);
    waitUntil(c + 6);
    check(outBusy[2] == 1'b1, "R7", "busy in last cycle", int'(outBusy[2]), 1);
    waitUntil(c + 7);
    check(outBusy[2] == 1'b0, "R7", "free after length", int'(outBusy[2]), 0);
    waitUntil(c + 10);

    // R5 / R4: local vs network collision at output 3
    c = cyc;
    put(1, 3, 1'b0, 1); put(2, 3, 1'b1, 3); tick();
    expectAt(c + 4, 3, 2, "R5");
    expectAt(c + 10, 3, 1, "R4");
    waitUntil(c + 12);

    // R6: move pointer of output 5 to 3, then input 4 beats input 1
    c = cyc;
    put(2, 5, 1'b0, 1); tick();
    expectAt(c + 4, 5, 2, "R6");
    waitUntil(c + 8);
    c = cyc;
    put(1, 5, 1'b0, 1); put(4, 5, 1'b0, 1); tick();
    expectAt(c + 4, 5, 4, "R6");
    expectAt(c + 8, 5, 1, "R4");
    waitUntil(c + 10);

    // R3: older packet in slot 1 beats younger packet in slot 0
    c = cyc;
    put(0, 6, 1'b1, 6); put(5, 1, 1'b1, 1); tick();
    put(5, 6, 1'b1, 2); tick();
    expectAt(c + 4, 1, 5, "R2");
    expectAt(c + 4, 6, 0, "R2");
    waitUntil(c + 5);
    put(5, 6, 1'b1, 5); tick();
    expectAt(c + 13, 6, 5, "R3");
    expectAt(c + 18, 6, 5, "R3");
    waitUntil(c + 15);
    check(outBusy[6] == 1'b0, "R3", "short older packet went first", int'(outBusy[6]), 0);
    waitUntil(c + 25);

    // R10: reset in mid-flight flushes the grant and the pointers
    c = cyc;
    put(3, 0, 1'b1, 2); tick();
    waitUntil(c + 2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    waitUntil(c + 10);
    check(queueFull == '0, "R10", "queues empty after reset", int'(queueFull), 0);
    check(outBusy == '0, "R10", "outputs free after reset", int'(outBusy), 0);
    c = cyc;
    put(1, 5, 1'b0, 1); put(4, 5, 1'b0, 1); tick();
    expectAt(c + 4, 5, 1, "R10");
    expectAt(c + 8, 5, 4, "R4");
    waitUntil(c + 10);

    // R1 / R8 / R9: fill input 7 behind a long transfer on output 4
    c = cyc;
    put(6, 4, 1'b1, 15); tick();
    expectAt(c + 4, 4, 6, "R2");
    waitUntil(c + 5);
    for (int k = 0; k < 4; k++) begin
      put(7, 4, 1'b0, 1); tick();
    end
    check(queueFull[7] == 1'b1, "R1", "queue full after four", int'(queueFull[7]), 1);
    put(7, 0, 1'b1, 1);   // R1: ignored, queue full
    put(2, 7, 1'b1, 1);   // R1: ignored, invalid destination
    tick();
    check(queueFull[7] == 1'b1, "R1", "full queue unchanged", int'(queueFull[7]), 1);
    check(queueFull[2] == 1'b0, "R1", "invalid destination not stored", int'(queueFull[2]), 0);
    expectAt(c + 22, 4, 7, "R8");
    expectAt(c + 26, 4, 7, "R4");
    expectAt(c + 30, 4, 7, "R4");
    expectAt(c + 34, 4, 7, "R4");
    waitUntil(c + 21);
    check(queueFull[7] == 1'b1, "R9", "still full before grant", int'(queueFull[7]), 1);
    waitUntil(c + 22);
    check(queueFull[7] == 1'b0, "R9", "slot freed at grant", int'(queueFull[7]), 0);
    waitUntil(c + 42);

    check(expQ.size() == 0, "R2", "expected grants left over", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule